// File: doc/BRIEF.md
# Execution-Phase Byte FIFO with Threshold Service Request

This block holds the bytes that move between a host bus and a disk data stream while a data-transfer command runs. In the execution phase it acts as a queue of up to 16 bytes and raises a service request (for a DMA channel or an interrupt line) once enough data, or enough free room, has built up. The level that triggers the request is a programmable 4-bit threshold. Outside the execution phase the queue shrinks to a single byte, so command and result bytes pass through one holding register one at a time.

The direction of flow comes from the phase and the transfer direction. In the command phase, and in the execution phase of a disk-write command, the host writes and the disk side (the controller engine) pops. In the result phase, and in the execution phase of a disk-read command, the disk side pushes and the host reads. The request can run in burst mode, where it stays high until the whole session has moved. It can also run in non-burst mode, where it drops for a fixed gap after every host transfer so that other requesters get a turn. Configuration is captured from a load strobe. A software reset keeps it only while the lock bit is set. A hardware reset always clears it.

Top module: `fx_exec_fifo`

## Requirements
- R1: After hardware reset, `svc_req` and `xfer_err` are low, and the FIFO is disabled with threshold 0. In a disk-read execution phase, one disk push raises `svc_req` and a second disk push sets `xfer_err`.
- R2: With the FIFO enabled, in the execution phase and for a direction that is not disabled, the queue holds 16 bytes. `rd_data` shows the oldest byte, and bytes leave in arrival order.
- R3: In phase 2'b00 (command), and in 2'b10 or 2'b11 (result), the queue holds one byte. A write into a full holding byte is dropped, and `svc_req` stays low.
- R4: In a disk-read execution phase (`disk_rd`=1), `svc_req` rises in the cycle after the push that brings the byte count to threshold+1.
- R5: In a disk-write execution phase (`disk_rd`=0), `svc_req` is high whenever the free space is at least threshold+1.
- R6: In burst mode, once `svc_req` has risen it stays high until the queue is empty (disk read) or full (disk write).
- R7: In non-burst mode, each host transfer in the execution phase drops `svc_req` for GAP_CYC cycles, after which it returns if the session is still open. Burst mode has no gap.
- R8: `cfg_rd_dis` (for disk reads) and `cfg_wr_dis` (for disk writes) each force their own direction to one-byte depth with threshold 0, and leave the other direction at full depth.
- R9: In the execution phase, a disk push into a full queue (disk read) or a disk pop from an empty queue (disk write) sets `xfer_err`. The flag holds until the phase is command (2'b00) or a software reset occurs.
- R10: A software reset empties the queue and clears `xfer_err`. It keeps the configuration when the lock bit is set. Otherwise it clears enable, threshold and the mode bits.
- R11: Any change of `phase` empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (24 MHz nominal) |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| soft_rst | input | 1 | Software reset, synchronous, active high |
| phase | input | 2 | 00 command, 01 execution, 10/11 result |
| disk_rd | input | 1 | 1: disk-read command, 0: disk-write command |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe (pops the head byte) |
| disk_push | input | 1 | Disk-side byte push |
| disk_wdata | input | 8 | Disk-side push data |
| disk_pop | input | 1 | Disk-side byte pop |
| cfg_load | input | 1 | Captures the configuration inputs |
| cfg_en | input | 1 | FIFO enable |
| cfg_thr | input | 4 | Request threshold |
| cfg_burst | input | 1 | 1: burst mode, 0: non-burst |
| cfg_rd_dis | input | 1 | Disable FIFO for disk reads |
| cfg_wr_dis | input | 1 | Disable FIFO for disk writes |
| cfg_lock | input | 1 | Keep configuration across software reset |
| svc_req | output | 1 | Service request for DMA or interrupt |
| rd_data | output | 8 | Head byte of the queue |
| xfer_err | output | 1 | Sticky overrun/underrun flag |

## Verification
A wrong byte count shows at once at the ports. The request rises one push early or late against threshold+1, and a count that does not reach zero after a flush makes `rd_data` show a stale byte at the next push. A lost configuration bit appears on the first execution-phase transfer, where the request comes at the wrong depth or the error flag sets on the second push. A gap counter that is off by one shows as a request returning one cycle early or late after a host transfer.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int unsigned FX_THR_W = 4;

  typedef enum logic [1:0] {
    PH_CMD  = 2'b00,
    PH_EXEC = 2'b01,
    PH_RES  = 2'b10,
    PH_RES2 = 2'b11
  } phase_e;

  typedef struct packed {
    logic                en;
    logic [FX_THR_W-1:0] thr;
    logic                burst;
    logic                rd_dis;
    logic                wr_dis;
  } fx_mode_t;
endpackage

// File: rtl/fx_cfg_regs.sv
module fx_cfg_regs
  import fx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst_i,
  input  logic     load_i,
  input  fx_mode_t mode_i,
  input  logic     lock_i,
  output fx_mode_t mode_o,
  output logic     lock_o
);
  fx_mode_t mode_q, mode_d;
  logic     lock_q, lock_d;

  always_comb begin
    mode_d = mode_q;
    lock_d = lock_q;
    if (soft_rst_i) begin
      if (!lock_q) mode_d = '0;
    end else if (load_i) begin
      mode_d = mode_i;
      lock_d = lock_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lock_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lock_q <= lock_d;
    end
  end

  assign mode_o = mode_q;
  assign lock_o = lock_q;

  // R10
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_i && lock_q) |=> (mode_q == $past(mode_q)));

  // R10
  unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_i && !lock_q) |=> (!mode_q.en && mode_q.thr == '0));
endmodule

// File: rtl/fx_queue.sv
module fx_queue #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  input  logic [CNT_W-1:0]  cap_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  level_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full_o  = (cnt_q >= cap_i);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = ptr_inc(wr_q);
      if (pop_ok)  rd_d = ptr_inc(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_q];
  assign level_o = cnt_q;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt_q == '0));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i && !flush_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/fx_req.sv
module fx_req #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned THR_W   = 4,
  parameter int unsigned GAP_CYC = 9,
  localparam int unsigned GAP_W  = $clog2(GAP_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             exec_i,
  input  logic             host_to_disk_i,
  input  logic [CNT_W-1:0] level_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             burst_i,
  input  logic             host_xfer_i,
  output logic             req_o
);
  logic             sess_q, sess_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [CNT_W-1:0] free;
  logic             start, done, open;

  assign free = cap_i - level_i;

  always_comb begin
    if (host_to_disk_i) begin
      start = int'(free) >= int'(thr_i) + 1;
      done  = (free == '0);
    end else begin
      start = int'(level_i) >= int'(thr_i) + 1;
      done  = (level_i == '0);
    end
    open = exec_i && (start || (sess_q && !done));
  end

  always_comb begin
    sess_d = clr_i ? 1'b0 : open;
    gap_d  = gap_q;
    if (clr_i)                        gap_d = '0;
    else if (host_xfer_i && !burst_i) gap_d = GAP_W'(GAP_CYC);
    else if (gap_q != '0)             gap_d = gap_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      sess_q <= sess_d;
      gap_q  <= gap_d;
    end
  end

  assign req_o = open && (burst_i || gap_q == '0);

  // R7
  nb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_xfer_i && !burst_i && !clr_i) |=> (!req_o || burst_i));

  // R6
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && burst_i && exec_i && !clr_i && !host_xfer_i) |=> (req_o || !exec_i || !burst_i || done));
endmodule

// File: rtl/fx_exec_fifo.sv
module fx_exec_fifo
  import fx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned GAP_CYC = 9,
  parameter int unsigned SYNC_N  = 2,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [1:0]        phase,
  input  logic              disk_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              disk_push,
  input  logic [DATA_W-1:0] disk_wdata,
  input  logic              disk_pop,
  input  logic              cfg_load,
  input  logic              cfg_en,
  input  logic [3:0]        cfg_thr,
  input  logic              cfg_burst,
  input  logic              cfg_rd_dis,
  input  logic              cfg_wr_dis,
  input  logic              cfg_lock,
  output logic              svc_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              xfer_err
);
  // reset: asserted asynchronously, released through a synchronizer
  logic [SYNC_N-1:0] rs_q;
  logic              rstn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_N-2:0], 1'b1};
  end
  assign rstn_s = rs_q[SYNC_N-1];

  // configuration
  fx_mode_t mode_in, mode_q;
  logic     lock_q;

  assign mode_in = '{en: cfg_en, thr: cfg_thr, burst: cfg_burst,
                     rd_dis: cfg_rd_dis, wr_dis: cfg_wr_dis};

  fx_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rstn_s),
    .soft_rst_i (soft_rst),
    .load_i     (cfg_load),
    .mode_i     (mode_in),
    .lock_i     (cfg_lock),
    .mode_o     (mode_q),
    .lock_o     (lock_q)
  );

  // phase tracking and flow steering
  logic [1:0]          phase_q;
  logic                exec, cmd, flush, clr, host_to_disk, fifo_on;
  logic                q_push, q_pop, host_xfer;
  logic [DATA_W-1:0]   q_wdata;
  logic [CNT_W-1:0]    cap, q_level;
  logic [FX_THR_W-1:0] thr_eff;
  logic                q_full, q_empty;

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) phase_q <= PH_CMD;
    else         phase_q <= phase;
  end

  assign exec         = (phase == PH_EXEC);
  assign cmd          = (phase == PH_CMD);
  assign flush        = (phase != phase_q);
  assign clr          = soft_rst || flush;
  assign host_to_disk = cmd || (exec && !disk_rd);
  assign fifo_on      = exec && mode_q.en &&
                        !(disk_rd ? mode_q.rd_dis : mode_q.wr_dis);
  assign cap          = fifo_on ? CNT_W'(DEPTH) : CNT_W'(1);
  assign thr_eff      = fifo_on ? mode_q.thr : '0;
  assign q_push       = host_to_disk ? host_wr : disk_push;
  assign q_pop        = host_to_disk ? disk_pop : host_rd;
  assign q_wdata      = host_to_disk ? host_wdata : disk_wdata;
  assign host_xfer    = exec && (host_to_disk ? host_wr : host_rd);

  fx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
    .clk     (clk),
    .rst_n   (rstn_s),
    .flush_i (clr),
    .push_i  (q_push),
    .wdata_i (q_wdata),
    .pop_i   (q_pop),
    .cap_i   (cap),
    .rdata_o (rd_data),
    .level_o (q_level),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  fx_req #(.CNT_W(CNT_W), .THR_W(FX_THR_W), .GAP_CYC(GAP_CYC)) u_req (
    .clk            (clk),
    .rst_n          (rstn_s),
    .clr_i          (clr),
    .exec_i         (exec),
    .host_to_disk_i (host_to_disk),
    .level_i        (q_level),
    .cap_i          (cap),
    .thr_i          (thr_eff),
    .burst_i        (mode_q.burst),
    .host_xfer_i    (host_xfer),
    .req_o          (svc_req)
  );

  // sticky overrun/underrun flag
  logic err_q, err_d, err_set;

  assign err_set = exec && !flush &&
                   ((!host_to_disk && disk_push && q_full) ||
                    ( host_to_disk && disk_pop  && q_empty));

  always_comb begin
    err_d = err_q;
    if (soft_rst || cmd) err_d = 1'b0;
    else if (err_set)    err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign xfer_err = err_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstn_s)
    (xfer_err && phase != PH_CMD && !soft_rst) |=> xfer_err);

  // R3
  req_exec_only_chk: assert property (@(posedge clk) disable iff (!rstn_s)
    (phase != PH_EXEC) |-> !svc_req);

  // R10
  srst_empty_chk: assert property (@(posedge clk) disable iff (!rstn_s)
    soft_rst |=> (q_level == '0 && !xfer_err));
endmodule

// File: tb/tb_fx_exec_fifo.sv
module tb_fx_exec_fifo;
  localparam int GAP = 9;

  logic       clk = 1'b0;
  logic       rst_n, soft_rst, disk_rd;
  logic [1:0] phase;
  logic       host_wr, host_rd, disk_push, disk_pop;
  logic [7:0] host_wdata, disk_wdata, rd_data;
  logic       cfg_load, cfg_en, cfg_burst, cfg_rd_dis, cfg_wr_dis, cfg_lock;
  logic [3:0] cfg_thr;
  logic       svc_req, xfer_err;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  fx_exec_fifo #(.GAP_CYC(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .phase(phase),
    .disk_rd(disk_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .disk_push(disk_push), .disk_wdata(disk_wdata),
    .disk_pop(disk_pop), .cfg_load(cfg_load), .cfg_en(cfg_en),
    .cfg_thr(cfg_thr), .cfg_burst(cfg_burst), .cfg_rd_dis(cfg_rd_dis),
    .cfg_wr_dis(cfg_wr_dis), .cfg_lock(cfg_lock), .svc_req(svc_req),
    .rd_data(rd_data), .xfer_err(xfer_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hreset();
    rst_n = 1'b0; soft_rst = 1'b0; phase = 2'b00; disk_rd = 1'b0;
    host_wr = 1'b0; host_rd = 1'b0; disk_push = 1'b0; disk_pop = 1'b0;
    host_wdata = '0; disk_wdata = '0; cfg_load = 1'b0; cfg_en = 1'b0;
    cfg_thr = '0; cfg_burst = 1'b0; cfg_rd_dis = 1'b0; cfg_wr_dis = 1'b0;
    cfg_lock = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic set_cfg(input logic en, input logic [3:0] thr, input logic burst,
                         input logic rdd, input logic wrd, input logic lock);
    cfg_en = en; cfg_thr = thr; cfg_burst = burst;
    cfg_rd_dis = rdd; cfg_wr_dis = wrd; cfg_lock = lock; cfg_load = 1'b1;
    step(1);
    cfg_load = 1'b0;
  endtask

  task automatic set_phase(input logic [1:0] p);
    phase = p;
    step(1);
  endtask

  task automatic dpush(input logic [7:0] d);
    disk_wdata = d; disk_push = 1'b1; step(1); disk_push = 1'b0;
  endtask

  task automatic dpop();
    disk_pop = 1'b1; step(1); disk_pop = 1'b0;
  endtask

  task automatic hwr(input logic [7:0] d);
    host_wdata = d; host_wr = 1'b1; step(1); host_wr = 1'b0;
  endtask

  task automatic hrd();
    host_rd = 1'b1; step(1); host_rd = 1'b0;
  endtask

  task automatic srst();
    soft_rst = 1'b1; step(1); soft_rst = 1'b0;
  endtask

  task automatic t_reset();
    hreset();
    chk("R1 req after reset", 32'(svc_req), 0);
    chk("R1 err after reset", 32'(xfer_err), 0);
    disk_rd = 1'b1; set_phase(2'b01);
    dpush(8'h11);
    chk("R1 req at one byte", 32'(svc_req), 1);
    chk("R1 head byte", 32'(rd_data), 32'h11);
    dpush(8'h22);
    chk("R1 second push overruns", 32'(xfer_err), 1);
  endtask

  task automatic t_bypass();
    hreset();
    set_cfg(1'b1, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    hwr(8'hA5);
    chk("R3 cmd byte held", 32'(rd_data), 32'hA5);
    chk("R3 no req in cmd", 32'(svc_req), 0);
    hwr(8'h5A);
    chk("R3 second write dropped", 32'(rd_data), 32'hA5);
    dpop();
    hwr(8'h3C);
    chk("R3 next cmd byte", 32'(rd_data), 32'h3C);
    chk("R3 no err in cmd", 32'(xfer_err), 0);
    set_phase(2'b10);
    dpush(8'h77);
    chk("R3 result byte", 32'(rd_data), 32'h77);
    chk("R3 no req in result", 32'(svc_req), 0);
  endtask

  task automatic t_read_burst();
    hreset();
    set_cfg(1'b1, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    disk_rd = 1'b1; set_phase(2'b01);
    for (int i = 0; i < 3; i++) begin
      dpush(8'(i + 1));
      chk("R4 below threshold", 32'(svc_req), 0);
    end
    dpush(8'd4);
    chk("R4 at threshold+1", 32'(svc_req), 1);
    for (int i = 0; i < 4; i++) begin
      chk("R2 read order", 32'(rd_data), 32'(i + 1));
      hrd();
      chk("R6 burst hold until empty", 32'(svc_req), (i < 3) ? 32'd1 : 32'd0);
    end
  endtask

  task automatic t_write();
    hreset();
    set_cfg(1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 1'b0);
    disk_rd = 1'b0; set_phase(2'b01);
    chk("R5 req on empty write queue", 32'(svc_req), 1);
    for (int i = 0; i < 16; i++) begin
      hwr(8'(8'h40 + i));
      chk("R6 burst hold until full", 32'(svc_req), (i < 15) ? 32'd1 : 32'd0);
    end
    for (int i = 0; i < 6; i++) begin
      chk("R2 write order", 32'(rd_data), 32'(8'h40 + i));
      dpop();
      chk("R5 free space vs threshold", 32'(svc_req), (i < 5) ? 32'd0 : 32'd1);
    end
    chk("R9 no err on normal pops", 32'(xfer_err), 0);
  endtask

  task automatic t_nonburst();
    hreset();
    set_cfg(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    disk_rd = 1'b1; set_phase(2'b01);
    dpush(8'h01); dpush(8'h02); dpush(8'h03);
    chk("R7 req before gap", 32'(svc_req), 1);
    hrd();
    chk("R7 gap starts", 32'(svc_req), 0);
    step(GAP - 1);
    chk("R7 gap last cycle", 32'(svc_req), 0);
    step(1);
    chk("R7 req returns after gap", 32'(svc_req), 1);
    set_cfg(1'b1, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    hrd();
    chk("R7 burst has no gap", 32'(svc_req), 1);
  endtask

  task automatic t_dir_dis();
    hreset();
    set_cfg(1'b1, 4'd7, 1'b1, 1'b1, 1'b0, 1'b0);
    disk_rd = 1'b1; set_phase(2'b01);
    dpush(8'h21);
    chk("R8 read disabled threshold 0", 32'(svc_req), 1);
    dpush(8'h22);
    chk("R8 read disabled depth 1", 32'(xfer_err), 1);
    set_phase(2'b00);
    chk("R9 cleared in cmd phase", 32'(xfer_err), 0);
    disk_rd = 1'b0; set_phase(2'b01);
    hwr(8'h31); hwr(8'h32);
    dpop();
    chk("R8 write direction keeps depth", 32'(rd_data), 32'h32);
    dpop();
    chk("R8 write direction no err", 32'(xfer_err), 0);
  endtask

  task automatic t_underrun();
    hreset();
    disk_rd = 1'b0; set_phase(2'b01);
    dpop();
    chk("R9 underrun sets", 32'(xfer_err), 1);
    step(3);
    chk("R9 sticky", 32'(xfer_err), 1);
    set_phase(2'b10);
    chk("R9 sticky in result", 32'(xfer_err), 1);
    set_phase(2'b00);
    chk("R9 cleared by cmd", 32'(xfer_err), 0);
  endtask

  task automatic t_soft();
    hreset();
    set_cfg(1'b1, 4'd3, 1'b1, 1'b0, 1'b0, 1'b1);
    disk_rd = 1'b1; set_phase(2'b01);
    dpush(8'h01); dpush(8'h02);
    srst();
    for (int i = 0; i < 3; i++) dpush(8'(i));
    chk("R10 flushed and threshold kept", 32'(svc_req), 0);
    dpush(8'h09);
    chk("R10 locked config survives", 32'(svc_req), 1);
    set_cfg(1'b1, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    srst();
    dpush(8'h0A);
    chk("R10 unlocked threshold cleared", 32'(svc_req), 1);
    dpush(8'h0B);
    chk("R10 unlocked enable cleared", 32'(xfer_err), 1);
    srst();
    chk("R10 soft reset clears err", 32'(xfer_err), 0);
  endtask

  task automatic t_flush();
    hreset();
    set_cfg(1'b1, 4'd15, 1'b1, 1'b0, 1'b0, 1'b0);
    disk_rd = 1'b1; set_phase(2'b01);
    dpush(8'hAA); dpush(8'hBB);
    chk("R11 head before change", 32'(rd_data), 32'hAA);
    set_phase(2'b10);
    dpush(8'hCC);
    chk("R11 phase change flushes", 32'(rd_data), 32'hCC);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_read_burst();
    t_write();
    t_nonburst();
    t_dir_dis();
    t_underrun();
    t_soft();
    t_flush();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule